// File: doc/BRIEF.md
# Video Field-Start Detector from Sliced Sync

This block watches a one-bit, already-sliced sync stream (one sample per clock) and marks where every video field begins. Each sync pulse is measured in clocks and compared with a quarter of a programmable line period. Pulses wider than that threshold are vertical pulses. A run of vertical pulses with no narrower pulse between them forms one vertical interval, and each field has exactly one such interval. The first pulse of each interval marks the start of the field.

The sync input can use component sync of either polarity, or composite/embedded sync, which is always active-low. A pulse's width is only known at its trailing edge. For this reason the block records a free-running sample count at the leading edge. It then raises the field strobe together with that timestamp once the pulse has ended. A frame strobe goes with the field strobe of the first field of each frame, and the frame length is configurable from one to four fields.

Top module: `vsync_field_detector`

## Requirements
- R1: While `rst` is high, and in the cycle after a clock edge that samples `rst` high, `field_strb` and `frame_strb` are 0. After reset the sample counter, the field counter and the vertical-interval state are all cleared.
- R2: With `comp_mode`=0 and `pol_high`=0, the active sync level is 0. A pulse starts at a 1-to-0 transition and ends at the next 0-to-1 transition.
- R3: With `comp_mode`=0 and `pol_high`=1, the active sync level is 1. A pulse starts at a 0-to-1 transition and ends at the next 1-to-0 transition.
- R4: With `comp_mode`=1, pulses are always active-low, whatever value `pol_high` has.
- R5: A pulse is vertical only when its length in clocks is strictly greater than `line_period >> 2`. A pulse of exactly that length, or shorter, never produces a strobe.
- R6: If the active level is first sampled at clock edge k and last sampled at edge k+N-1, the strobe for a vertical pulse is high for exactly one cycle, following edge k+N+1.
- R7: Vertical pulses with no non-vertical pulse between them form one interval, and only the first of them produces a field strobe. A non-vertical pulse ends the interval, so the next vertical pulse produces a new strobe.
- R8: While `field_strb` is high, `field_ts` holds the leading-edge timestamp. This is the number of clock edges with `rst` low, up to and including the edge that first sampled the active level.
- R9: `frame_strb` is high together with `field_strb` for the first field of each frame. `field_idx` gives the 0-based position of the field in its frame. A frame has `fields_m1`+1 fields, and the first field after reset is index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_in | input | 1 | Sliced sync sample |
| comp_mode | input | 1 | 1 = composite/embedded sync (active-low); 0 = component sync |
| pol_high | input | 1 | Component polarity: 1 = active-high, 0 = active-low |
| line_period | input | 16 | Line period in clocks |
| fields_m1 | input | 2 | Fields per frame minus one |
| field_strb | output | 1 | One-cycle field-start strobe |
| frame_strb | output | 1 | One-cycle frame-start strobe (only together with field_strb) |
| field_ts | output | 32 | Leading-edge timestamp of the strobed pulse |
| field_idx | output | 2 | Field position within its frame |

## Verification
The hardest situation to reach is the end of a vertical interval. Several wide pulses must arrive back to back, and only then may a narrow pulse rearm detection. The stimulus drives trains of three wide pulses separated by gaps and expects a single strobe stamped with the first pulse's leading edge. A narrow pulse then follows, and a fresh wide pulse must produce a new strobe. Pulses of exactly a quarter line and one clock more probe the threshold. Mode and polarity switches are made together with a change of the idle level, so that no false edge appears.

// File: rtl/vsd_pkg.sv
package vsd_pkg;
   localparam int unsigned DEF_LINE_W     = 16;
   localparam int unsigned DEF_TS_W       = 32;
   localparam int unsigned DEF_MAX_FIELDS = 4;

   function automatic int unsigned fc_width(input int unsigned max_fields);
      return (max_fields > 1) ? $clog2(max_fields) : 1;
   endfunction

   typedef struct packed {
      logic lead;
      logic trail;
      logic hold;
   } edge_ev_t;
endpackage

// File: rtl/vsd_polarity_edge.sv
module vsd_polarity_edge
   import vsd_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic     clk,
   input  logic     rst,
   input  logic     sync_in,
   input  logic     comp_mode,
   input  logic     pol_high,
   output edge_ev_t ev
);
   logic               act_raw;
   logic [SYNC_STAGES:0] pipe;
   logic               a_q, a_d;

   // composite ignores polarity: always active-low
   assign act_raw = comp_mode ? ~sync_in : (pol_high ? sync_in : ~sync_in);
   assign pipe[0] = act_raw;

   generate
      for (genvar i = 1; i <= SYNC_STAGES; i++) begin : g_stage
         always_ff @(posedge clk) begin
            if (rst) pipe[i] <= 1'b0;
            else     pipe[i] <= pipe[i-1];
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         a_q <= 1'b0;
         a_d <= 1'b0;
      end else begin
         a_q <= pipe[SYNC_STAGES];
         a_d <= a_q;
      end
   end

   assign ev.lead  = a_q & ~a_d;
   assign ev.trail = ~a_q & a_d;
   assign ev.hold  = a_q & a_d;

   assert_lead_single_R2: assert property (@(posedge clk) disable iff (rst)
      ev.lead |=> !ev.lead);
endmodule

// File: rtl/vsd_pulse_meas.sv
module vsd_pulse_meas
   import vsd_pkg::*;
#(
   parameter int unsigned LINE_W = DEF_LINE_W,
   parameter int unsigned TS_W   = DEF_TS_W,
   localparam int unsigned WID_W = LINE_W + 1
) (
   input  logic              clk,
   input  logic              rst,
   input  edge_ev_t          ev,
   output logic              done,
   output logic [WID_W-1:0]  width,
   output logic [TS_W-1:0]   lead_ts
);
   localparam logic [WID_W-1:0] WID_MAX = '1;
   logic [TS_W-1:0] ts_cnt;

   always_ff @(posedge clk) begin
      if (rst) ts_cnt <= '0;
      else     ts_cnt <= ts_cnt + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         width   <= '0;
         lead_ts <= '0;
      end else if (ev.lead) begin
         width   <= WID_W'(1);
         lead_ts <= ts_cnt;
      end else if (ev.hold && width != WID_MAX) begin
         width <= width + 1'b1;
      end
   end

   assign done = ev.trail;

   assert_width_nonzero_R6: assert property (@(posedge clk) disable iff (rst)
      done |-> width != '0);
endmodule

// File: rtl/vsd_vint_tracker.sv
module vsd_vint_tracker
   import vsd_pkg::*;
#(
   parameter int unsigned LINE_W     = DEF_LINE_W,
   parameter int unsigned TS_W       = DEF_TS_W,
   parameter int unsigned MAX_FIELDS = DEF_MAX_FIELDS,
   localparam int unsigned WID_W = LINE_W + 1,
   localparam int unsigned FC_W  = fc_width(MAX_FIELDS)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              done,
   input  logic [WID_W-1:0]  width,
   input  logic [TS_W-1:0]   lead_ts,
   input  logic [LINE_W-1:0] line_period,
   input  logic [FC_W-1:0]   fields_m1,
   output logic              field_strb,
   output logic              frame_strb,
   output logic [TS_W-1:0]   field_ts,
   output logic [FC_W-1:0]   field_idx
);
   logic [WID_W-1:0] thresh;
   logic             is_vert, in_vint, new_field;
   logic [FC_W-1:0]  fcnt;

   assign thresh    = WID_W'(line_period >> 2);
   assign is_vert   = width > thresh;
   assign new_field = done & is_vert & ~in_vint;

   always_ff @(posedge clk) begin
      if (rst)       in_vint <= 1'b0;
      else if (done) in_vint <= is_vert;
   end

   generate
      if (MAX_FIELDS > 1) begin : g_multi
         always_ff @(posedge clk) begin
            if (rst) fcnt <= '0;
            else if (new_field) fcnt <= (fcnt >= fields_m1) ? '0 : fcnt + 1'b1;
         end
      end else begin : g_single
         assign fcnt = '0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         field_strb <= 1'b0;
         frame_strb <= 1'b0;
         field_ts   <= '0;
         field_idx  <= '0;
      end else begin
         field_strb <= new_field;
         frame_strb <= new_field && fcnt == '0;
         if (new_field) begin
            field_ts  <= lead_ts;
            field_idx <= fcnt;
         end
      end
   end

   assert_reset_quiet_R1: assert property (@(posedge clk)
      rst |=> !field_strb && !frame_strb);
   assert_strobe_one_cycle_R6: assert property (@(posedge clk) disable iff (rst)
      field_strb |=> !field_strb);
   assert_frame_with_field_R9: assert property (@(posedge clk) disable iff (rst)
      frame_strb |-> field_strb);
   assert_interval_open_R7: assert property (@(posedge clk) disable iff (rst)
      field_strb |-> in_vint);
   assert_no_repeat_in_interval_R7: assert property (@(posedge clk) disable iff (rst)
      (done && in_vint && is_vert) |=> !field_strb);
endmodule

// File: rtl/vsync_field_detector.sv
module vsync_field_detector
   import vsd_pkg::*;
#(
   parameter int unsigned LINE_W      = DEF_LINE_W,
   parameter int unsigned TS_W        = DEF_TS_W,
   parameter int unsigned MAX_FIELDS  = DEF_MAX_FIELDS,
   parameter int unsigned SYNC_STAGES = 0,
   localparam int unsigned WID_W = LINE_W + 1,
   localparam int unsigned FC_W  = fc_width(MAX_FIELDS)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sync_in,
   input  logic              comp_mode,
   input  logic              pol_high,
   input  logic [LINE_W-1:0] line_period,
   input  logic [FC_W-1:0]   fields_m1,
   output logic              field_strb,
   output logic              frame_strb,
   output logic [TS_W-1:0]   field_ts,
   output logic [FC_W-1:0]   field_idx
);
   generate
      if (LINE_W < 3) begin : g_bad_line
         $error("LINE_W must be at least 3");
      end
      if (TS_W < 8) begin : g_bad_ts
         $error("TS_W must be at least 8");
      end
      if (MAX_FIELDS < 1 || MAX_FIELDS > 16) begin : g_bad_fields
         $error("MAX_FIELDS out of range");
      end
   endgenerate

   edge_ev_t         ev;
   logic             done;
   logic [WID_W-1:0] width;
   logic [TS_W-1:0]  lead_ts;

   vsd_polarity_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst(rst), .sync_in(sync_in),
      .comp_mode(comp_mode), .pol_high(pol_high), .ev(ev)
   );

   vsd_pulse_meas #(.LINE_W(LINE_W), .TS_W(TS_W)) u_meas (
      .clk(clk), .rst(rst), .ev(ev),
      .done(done), .width(width), .lead_ts(lead_ts)
   );

   vsd_vint_tracker #(.LINE_W(LINE_W), .TS_W(TS_W), .MAX_FIELDS(MAX_FIELDS)) u_vint (
      .clk(clk), .rst(rst), .done(done), .width(width), .lead_ts(lead_ts),
      .line_period(line_period), .fields_m1(fields_m1),
      .field_strb(field_strb), .frame_strb(frame_strb),
      .field_ts(field_ts), .field_idx(field_idx)
   );
endmodule

// File: tb/sim_vsync_field_detector.sv
module sim_vsync_field_detector;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        sync_in = 1'b1;
   logic        comp_mode = 1'b0;
   logic        pol_high = 1'b0;
   logic [15:0] line_period = 16'd64;
   logic [1:0]  fields_m1 = 2'd0;
   logic        field_strb, frame_strb;
   logic [31:0] field_ts;
   logic [1:0]  field_idx;

   int unsigned bcnt = 0;
   int          checks = 0, fails = 0;
   int          nstrb = 0;
   longint      last_ts, last_cyc;
   logic        last_frame;
   logic [1:0]  last_idx;

   vsync_field_detector u0 (
      .clk(clk), .rst(rst), .sync_in(sync_in), .comp_mode(comp_mode),
      .pol_high(pol_high), .line_period(line_period), .fields_m1(fields_m1),
      .field_strb(field_strb), .frame_strb(frame_strb),
      .field_ts(field_ts), .field_idx(field_idx)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      if (rst) bcnt <= 0;
      else     bcnt <= bcnt + 1;
   end

   always @(negedge clk) begin
      if (field_strb) begin
         nstrb++;
         last_ts    = field_ts;
         last_cyc   = bcnt;
         last_frame = frame_strb;
         last_idx   = field_idx;
      end
   end

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // one pulse of n clocks at level act, then gap clocks idle
   task automatic send(input int n, input logic act, input int gap, output longint ets);
      ets = longint'(bcnt) + 1;
      sync_in = act;
      repeat (n) @(negedge clk);
      sync_in = ~act;
      repeat (gap) @(negedge clk);
   endtask

   task automatic do_reset(input logic idle);
      rst = 1'b1;
      sync_in = idle;
      repeat (3) @(negedge clk);
      chk("R1 field_strb in reset", field_strb, 0);
      chk("R1 frame_strb in reset", frame_strb, 0);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 no strobe after reset", field_strb, 0);
   endtask

   task automatic t_comp_low;
      longint e, d;
      int base = nstrb;
      send(5, 1'b0, 20, d);
      chk("R5 narrow pulse no strobe", nstrb, base);
      send(30, 1'b0, 20, e);
      chk("R2 active-low vertical strobes", nstrb, base + 1);
      chk("R8 timestamp", last_ts, e);
      chk("R6 strobe cycle", last_cyc, e + 31);
      send(5, 1'b0, 20, d);
   endtask

   task automatic t_threshold;
      longint e, d;
      int base = nstrb;
      send(16, 1'b0, 20, d);
      chk("R5 quarter-line pulse not vertical", nstrb, base);
      send(17, 1'b0, 20, e);
      chk("R5 quarter+1 pulse vertical", nstrb, base + 1);
      chk("R8 threshold timestamp", last_ts, e);
      send(5, 1'b0, 20, d);
   endtask

   task automatic t_group;
      longint e1, e2, d;
      int base = nstrb;
      send(30, 1'b0, 10, e1);
      send(30, 1'b0, 10, d);
      send(30, 1'b0, 20, d);
      chk("R7 one strobe per interval", nstrb, base + 1);
      chk("R7 strobe marks first pulse", last_ts, e1);
      send(5, 1'b0, 20, d);
      send(30, 1'b0, 20, e2);
      chk("R7 new interval after narrow pulse", nstrb, base + 2);
      chk("R7 new interval timestamp", last_ts, e2);
      send(5, 1'b0, 20, d);
   endtask

   task automatic t_comp_high;
      longint e, d;
      int base = nstrb;
      pol_high = 1'b1;
      sync_in  = 1'b0;
      repeat (5) @(negedge clk);
      chk("R3 switch makes no strobe", nstrb, base);
      send(30, 1'b1, 20, e);
      chk("R3 active-high vertical strobes", nstrb, base + 1);
      chk("R3 timestamp", last_ts, e);
      send(5, 1'b1, 20, d);
   endtask

   task automatic t_composite;
      longint e, d;
      int base = nstrb;
      comp_mode = 1'b1;
      sync_in   = 1'b1;
      repeat (5) @(negedge clk);
      send(30, 1'b0, 20, e);
      chk("R4 composite active-low despite pol_high", nstrb, base + 1);
      chk("R4 timestamp", last_ts, e);
      send(5, 1'b0, 20, d);
      comp_mode = 1'b0;
      pol_high  = 1'b0;
      repeat (5) @(negedge clk);
   endtask

   task automatic t_frame;
      longint d;
      fields_m1 = 2'd2;
      do_reset(1'b1);
      for (int f = 0; f < 4; f++) begin
         send(30, 1'b0, 20, d);
         send(5, 1'b0, 20, d);
         chk("R9 field index", last_idx, f % 3);
         chk("R9 frame strobe", last_frame, (f % 3) == 0);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      @(negedge clk);
      do_reset(1'b1);
      t_comp_low();
      t_threshold();
      t_group();
      t_comp_high();
      t_composite();
      t_frame();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule